// File: doc/BRIEF.md
# Four-Bank Flow-Through Burst Static Memory

This block models a 72-bit synchronous static memory built from four banks. Every bank has the same word width and a parameterized depth. Address, strobes, enables and write controls are captured on the rising clock edge. Read data then comes straight out of the storage array, with no output register, so a word addressed at one edge is on the data pins before the next edge. Writes are early. The data and lane mask presented at an edge are stored at that same edge.

An access is started by one of two address strobes: a controller strobe and a processor strobe. It continues as a four-beat burst while the advance input is held low, which gives 2-1-1-1 timing. A static order input chooses a linear or an interleaved beat order. Each bank has a sleep input. The output enable gates the read data asynchronously. The read port has no back-pressure. Flow-through data is valid only in the cycle the address selects it, so a consumer takes it or loses it, and `rd_valid` marks the cycles that carry data.

Top module: `burst_sram72`

## Requirements
- R1: A word is 72 bits, made of eight 9-bit lanes. Lane k is bits 9k+8..9k. There are four banks of DEPTH words each, and bank i is chosen by a low level on `bank_sel_n[i]`.
- R2: All controls except `out_en_n` and `bank_sleep` are sampled on the rising edge. A start needs `mod_sel_n` low and exactly one bank select low. Read data for the access registered at an edge appears, with `rd_valid` high, before the next edge.
- R3: At an access edge with `all_wr_n` low, all eight lanes of the addressed word are written from `wr_data`, whatever the lane strobes are.
- R4: With `all_wr_n` high and `lane_wr_en_n` low, only the lanes whose `lane_wr_n[k]` is low are written. With neither write control active, the access is a read.
- R5: In the cycle after a write edge, `rd_valid` is low and `rd_data` is zero. Data written is returned by a later read of the same word.
- R6: At an edge that continues a burst, `step_n` low advances a 2-bit beat count, and the count wraps to the start word after four beats. With `step_n` high, the same word stays addressed. The write controls apply to each beat.
- R7: The low two address bits of a beat are start XOR count when `ilv_order` is 1, and (start + count) mod 4 when it is 0. The upper address bits stay at their start value.
- R8: If both strobes are low, the controller strobe wins and write controls are honoured. A start made by the processor strobe alone is always a read, and its write controls are ignored.
- R9: A low `cpu_stb_n` is ignored while `mod_sel_n` is high, and the burst then continues under `step_n`. A controller strobe while `mod_sel_n` is high, or any strobe while not exactly one bank select is low, deselects the memory: `rd_valid` stays low until the next start.
- R10: A bank whose `bank_sleep` bit is high is never written. While it sleeps, reads from it give `rd_valid` low and `rd_data` zero.
- R11: `out_en_n` high forces `rd_valid` low and `rd_data` to zero without waiting for a clock.
- R12: With `ctl_stb_n` held low and the other strobe and `step_n` held high, every cycle is an independent single access to the address presented.
- R13: During and after reset, until the first start, `rd_valid` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| addr | input | AW | Word address within a bank |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, read start only |
| step_n | input | 1 | Burst advance, active low |
| ilv_order | input | 1 | Beat order: 1 interleaved, 0 linear |
| mod_sel_n | input | 1 | Module enable, active low |
| bank_sel_n | input | NB | Bank enables, active low, exactly one for an access |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_wr_n | input | LANES | Lane write strobes, active low |
| wr_data | input | 72 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| bank_sleep | input | NB | Per-bank sleep, active high |
| rd_data | output | 72 | Flow-through read data, zero when not valid |
| rd_valid | output | 1 | Read data valid in this cycle |

## Verification
The assertions assume that `ilv_order` does not change during a burst. They also assume that `out_en_n` and `bank_sleep` change only away from clock edges, so that `rd_data` is stable during a held read. The stimulus changes every input only on the falling edge and sets the order input only between bursts. The data-hold property is limited to edges with no strobe, no advance and no write control, which are the only edges at which the addressed word cannot move or change.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // Low two bits of the word addressed by beat `cnt` of a burst begun at `start`.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] cnt,
                                         input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/bsr_bank.sv
module bsr_bank #(
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] lane_mask,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_mask[g]) cells[wr_addr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = cells[rd_addr];
  end
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl import bsr_pkg::*; #(
  parameter int NB    = 4,
  parameter int AW    = 4,
  parameter int LANES = 8,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ctl_stb_n,
  input  logic             cpu_stb_n,
  input  logic             step_n,
  input  logic             ilv_order,
  input  logic             mod_sel_n,
  input  logic [NB-1:0]    bank_sel_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             wr_go,
  output logic [BW-1:0]    wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_q,
  output logic [BW-1:0]    bank_q,
  output logic [AW-1:0]    rd_addr
);
  logic          act_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;

  int            hits;
  logic [BW-1:0] pick;
  logic          one_bank, start_c, start_p, desel, cont;
  logic          nxt_act;
  logic [AW-1:0] nxt_base;
  logic [BW-1:0] nxt_bank;
  logic [1:0]    nxt_cnt;
  logic          wr_req;

  always_comb begin
    hits = 0;
    pick = '0;
    for (int i = 0; i < NB; i++) begin
      if (!bank_sel_n[i]) begin
        hits = hits + 1;
        pick = BW'(i);
      end
    end
  end

  assign one_bank = (hits == 1);
  assign start_c  = !ctl_stb_n && !mod_sel_n && one_bank;
  assign start_p  = ctl_stb_n && !cpu_stb_n && !mod_sel_n && one_bank;
  assign desel    = (!ctl_stb_n && (mod_sel_n || !one_bank)) ||
                    (ctl_stb_n && !cpu_stb_n && !mod_sel_n && !one_bank);
  assign cont     = act_q && !start_c && !start_p && !desel;

  assign nxt_act  = start_c || start_p || cont;
  assign nxt_base = (start_c || start_p) ? addr : base_q;
  assign nxt_bank = (start_c || start_p) ? pick : bank_q;
  assign nxt_cnt  = (start_c || start_p) ? 2'd0 :
                    (cont && !step_n)    ? cnt_q + 2'd1 : cnt_q;

  always_comb begin
    if (!all_wr_n)          wr_mask = '1;
    else if (!lane_wr_en_n) wr_mask = ~lane_wr_n;
    else                    wr_mask = '0;
  end

  assign wr_req  = |wr_mask;
  assign wr_go   = nxt_act && !start_p && wr_req;
  assign wr_bank = nxt_bank;

  if (AW > 2) begin : g_wide
    assign wr_addr = {nxt_base[AW-1:2], beat_lo(nxt_base[1:0], nxt_cnt, ilv_order)};
    assign rd_addr = {base_q[AW-1:2],   beat_lo(base_q[1:0],   cnt_q,   ilv_order)};
  end else begin : g_narrow
    assign wr_addr = beat_lo(nxt_base[1:0], nxt_cnt, ilv_order);
    assign rd_addr = beat_lo(base_q[1:0],   cnt_q,   ilv_order);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= nxt_act;
      rd_q   <= nxt_act && !wr_go;
      base_q <= nxt_base;
      bank_q <= nxt_bank;
      cnt_q  <= nxt_cnt;
    end
  end
endmodule

// File: rtl/burst_sram72.sv
module burst_sram72 #(
  parameter int NB    = 4,
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ctl_stb_n,
  input  logic             cpu_stb_n,
  input  logic             step_n,
  input  logic             ilv_order,
  input  logic             mod_sel_n,
  input  logic [NB-1:0]    bank_sel_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    wr_data,
  input  logic             out_en_n,
  input  logic [NB-1:0]    bank_sleep,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  logic             wr_go, rd_q;
  logic [BW-1:0]    wr_bank, bank_q;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [LANES-1:0] wr_mask;
  logic [NB-1:0]    bank_we;
  logic [DW-1:0]    bank_rd [NB];

  bsr_ctrl #(.NB(NB), .AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n), .step_n(step_n),
    .ilv_order(ilv_order), .mod_sel_n(mod_sel_n), .bank_sel_n(bank_sel_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .wr_go(wr_go), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .rd_q(rd_q), .bank_q(bank_q), .rd_addr(rd_addr)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_we[b] = wr_go && (wr_bank == BW'(b)) && !bank_sleep[b];
    bsr_bank #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW)) u_bank (
      .clk(clk), .we(bank_we[b]), .lane_mask(wr_mask), .wr_addr(wr_addr),
      .wdata(wr_data), .rd_addr(rd_addr), .rdata(bank_rd[b])
    );
  end

  assign rd_valid = rd_q && !out_en_n && !bank_sleep[bank_q];
  assign rd_data  = rd_valid ? bank_rd[bank_q] : '0;
endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
  parameter int NB    = 4,
  parameter int LANES = 8,
  parameter int DW    = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_stb_n,
  input logic          cpu_stb_n,
  input logic          step_n,
  input logic          mod_sel_n,
  input logic [NB-1:0] bank_sel_n,
  input logic          all_wr_n,
  input logic          lane_wr_en_n,
  input logic          out_en_n,
  input logic [NB-1:0] bank_we,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid
);
  // R11: a disabled output never reports data
  a_r11_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rd_valid && rd_data == '0));

  // R9: a controller strobe with the module disabled deselects
  a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_stb_n && mod_sel_n) |=> !rd_valid);

  // R5: a global write start yields no read data in the following cycle
  a_r5_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_stb_n && !mod_sel_n && !all_wr_n && $onehot(~bank_sel_n)) |=> !rd_valid);

  // R1: at most one bank is written at an edge
  a_r1_one_bank_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R6: with no strobe, advance or write, the addressed word holds
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stb_n && cpu_stb_n && step_n && all_wr_n && lane_wr_en_n && rd_valid)
    |=> (!rd_valid || $stable(rd_data)));
endmodule

bind burst_sram72 bsr_chk #(.NB(NB), .LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n),
  .step_n(step_n), .mod_sel_n(mod_sel_n), .bank_sel_n(bank_sel_n),
  .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .out_en_n(out_en_n),
  .bank_we(bank_we), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/sim_burst_sram72.sv
`timescale 1ns/1ps
module sim_burst_sram72;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        ctl_stb_n = 1'b1, cpu_stb_n = 1'b1, step_n = 1'b1;
  logic        ilv_order = 1'b0, mod_sel_n = 1'b0;
  logic [3:0]  bank_sel_n = 4'hF;
  logic        all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [7:0]  lane_wr_n = 8'hFF;
  logic [71:0] wr_data = '0;
  logic        out_en_n = 1'b0;
  logic [3:0]  bank_sleep = '0;
  logic [71:0] rd_data;
  logic        rd_valid;

  int tests = 0, fails = 0;

  // reference state
  logic [71:0] m_mem [4][16];
  bit m_act = 0, m_rd = 0;
  int m_bank = 0, m_base = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  burst_sram72 u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl_stb_n(ctl_stb_n),
    .cpu_stb_n(cpu_stb_n), .step_n(step_n), .ilv_order(ilv_order),
    .mod_sel_n(mod_sel_n), .bank_sel_n(bank_sel_n), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n), .wr_data(wr_data),
    .out_en_n(out_en_n), .bank_sleep(bank_sleep), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  function automatic int m_addr();
    int lo;
    lo = ilv_order ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4);
    return (m_base & ~3) | lo;
  endfunction

  function automatic logic [71:0] pat(int b, int a);
    return {8{9'((b * 16 + a) * 7 + 3)}};
  endfunction

  task automatic model_edge();
    int n = 0, b = 0;
    bit sc, sp, ds, wr;
    for (int i = 0; i < 4; i++) if (!bank_sel_n[i]) begin n++; b = i; end
    sc = !ctl_stb_n && !mod_sel_n && n == 1;
    sp = ctl_stb_n && !cpu_stb_n && !mod_sel_n && n == 1;
    ds = (!ctl_stb_n && (mod_sel_n || n != 1)) || (ctl_stb_n && !cpu_stb_n && !mod_sel_n && n != 1);
    if (!rst_n) m_act = 0;
    else if (sc || sp) begin m_act = 1; m_bank = b; m_base = int'(addr); m_cnt = 0; end
    else if (ds) m_act = 0;
    else if (m_act && !step_n) m_cnt = (m_cnt + 1) % 4;
    wr = m_act && !sp && (!all_wr_n || (!lane_wr_en_n && lane_wr_n != 8'hFF));
    if (wr && !bank_sleep[m_bank])
      for (int k = 0; k < 8; k++)
        if (!all_wr_n || !lane_wr_n[k]) m_mem[m_bank][m_addr()][9*k +: 9] = wr_data[9*k +: 9];
    m_rd = m_act && !wr;
  endtask

  task automatic check(string tag);
    bit ev;
    logic [71:0] ed;
    ev = m_rd && !out_en_n && !bank_sleep[m_bank];
    ed = ev ? m_mem[m_bank][m_addr()] : 72'h0;
    tests++;
    if (rd_valid !== ev || rd_data !== ed) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", tag, rd_valid, rd_data, ev, ed);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
    ctl_stb_n = 1; cpu_stb_n = 1; step_n = 1; all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = 8'hFF;
  endtask

  task automatic sel(int b);
    bank_sel_n = ~(4'b0001 << b);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) tick("R13");
    rst_n = 1;
    tick("R13");

    // R3, R5: fill every word with a global write
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 16; a++) begin
        ctl_stb_n = 0; sel(b); addr = 4'(a); all_wr_n = 0; wr_data = pat(b, a);
        tick("R5");
      end

    // R12, R2, R1: single accesses every cycle
    for (int i = 0; i < 8; i++) begin
      ctl_stb_n = 0; sel(i % 4); addr = 4'(i * 5);
      tick("R12");
    end

    // R4: lane writes then read back
    ctl_stb_n = 0; sel(1); addr = 4'd7; lane_wr_en_n = 0; lane_wr_n = 8'b1010_0101; wr_data = '1;
    tick("R4");
    ctl_stb_n = 0; sel(1); addr = 4'd7; lane_wr_n = 8'h00; wr_data = '0;
    tick("R4");
    ctl_stb_n = 0; sel(1); addr = 4'd7;
    tick("R4");

    // R6, R7: linear burst with wrap and hold
    ilv_order = 0;
    ctl_stb_n = 0; sel(1); addr = 4'd6;
    tick("R6");
    for (int i = 0; i < 4; i++) begin step_n = 0; tick("R7"); end
    tick("R6");

    // R7: interleaved burst started by the processor strobe
    ilv_order = 1;
    cpu_stb_n = 0; sel(2); addr = 4'd9;
    tick("R7");
    for (int i = 0; i < 3; i++) begin step_n = 0; tick("R7"); end
    ilv_order = 0;

    // R6: burst write then burst read back
    ctl_stb_n = 0; sel(3); addr = 4'd4; all_wr_n = 0; wr_data = {8{9'h1A5}};
    tick("R6");
    for (int i = 0; i < 3; i++) begin step_n = 0; all_wr_n = 0; wr_data = {8{9'(i + 40)}}; tick("R6"); end
    ctl_stb_n = 0; sel(3); addr = 4'd4;
    tick("R6");
    for (int i = 0; i < 3; i++) begin step_n = 0; tick("R6"); end

    // R8: strobe priority and processor start is read-only
    ctl_stb_n = 0; cpu_stb_n = 0; sel(0); addr = 4'd2; all_wr_n = 0; wr_data = {8{9'h0F0}};
    tick("R8");
    cpu_stb_n = 0; sel(0); addr = 4'd3; all_wr_n = 0; wr_data = {8{9'h111}};
    tick("R8");
    ctl_stb_n = 0; sel(0); addr = 4'd2;
    tick("R8");
    ctl_stb_n = 0; sel(0); addr = 4'd3;
    tick("R8");

    // R9: ignored processor strobe, deselects
    ctl_stb_n = 0; sel(1); addr = 4'd0;
    tick("R9");
    mod_sel_n = 1; cpu_stb_n = 0; step_n = 0; addr = 4'd8;
    tick("R9");
    ctl_stb_n = 0;
    tick("R9");
    mod_sel_n = 0; step_n = 0;
    tick("R9");
    ctl_stb_n = 0; bank_sel_n = 4'b0011; addr = 4'd1;
    tick("R9");
    ctl_stb_n = 0; sel(1); addr = 4'd1;
    tick("R2");
    cpu_stb_n = 0; bank_sel_n = 4'hF;
    tick("R9");

    // R10: sleeping bank
    bank_sleep = 4'b0100;
    ctl_stb_n = 0; sel(2); addr = 4'd5; all_wr_n = 0; wr_data = '1;
    tick("R10");
    ctl_stb_n = 0; sel(2); addr = 4'd5;
    tick("R10");
    bank_sleep = 4'b0000;
    #1 check("R10");
    ctl_stb_n = 0; sel(2); addr = 4'd5;
    tick("R10");

    // R11: asynchronous output enable
    ctl_stb_n = 0; sel(0); addr = 4'd10;
    tick("R11");
    out_en_n = 1;
    #1 check("R11");
    out_en_n = 0;
    #1 check("R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule